// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel

This block is one DMA channel. When armed, it fetches an eight-byte configuration record from memory and then copies items from a source address to a destination address. An item is a byte or a 16-bit word. All traffic uses one synchronous memory port, and read data returns one cycle after the request. The record sets several things:

- the item size;
- how many items to move, either a fixed length or a count taken from the first item read plus a selectable offset;
- whether each trigger moves one item or the whole block;
- whether the channel reloads and stays armed after finishing;
- how each address steps after each item;
- whether completion raises an interrupt.

A software request input and a vector of hardware trigger pulses start the movement. The record selects which hardware line the channel listens to. An abort input drops the channel back to idle at any point. The block exposes the record's two-bit priority field so that an arbiter outside the block can use it. Arbitration between channels is not part of this block.

Top module: `dma_chan_engine`

## Requirements
- R1: A one-cycle `arm` pulse while idle makes the channel read 8 bytes from `desc_addr` upward and then wait for a trigger with `armed` high. The byte order is: source high, source low, destination high, destination low, length high, length low, config byte, control byte. While `armed` is low the memory port stays quiet.
- R2: An `sw_req` pulse always starts movement. The hardware line `trig_vec[n]` starts it only when n is the trigger number in config bits [4:0] and n is at least 1. Number 0 means only `sw_req` counts, and line 1 carries the previous channel's completion. Pulses on other lines have no effect.
- R3: Config bits [6:5] select the mode. Value 00 moves one item per trigger. Value 01 moves the whole count on one trigger. Each write is issued in the cycle after the read of the same item.
- R4: Mode 10 (repeated single) and mode 11 (repeated block) reload the addresses and count from the stored record when the count completes, and `armed` stays high. Modes 00 and 01 return to idle.
- R5: Control bits [7:6] set the source stepping and control bits [5:4] set the destination stepping. The codes are 00 hold, 01 forward one item, 10 forward two items and 11 back one item. Addresses wrap modulo 2^16.
- R6: Config bit 7 set selects 16-bit items. Each item is two bytes, low byte first, at the item's address.
- R7: Length-high bits [7:5] select the count mode. Values 0, 5, 6 and 7 use the 13-bit length {length-high[4:0], length-low} as the count. A fixed count of zero finishes on the trigger without any memory write.
- R8: Count modes 1, 2, 3 and 4 take the first item's value n and use n+1, n, n+2 and n+3 items respectively. The first item is counted in that total, and the total is capped at the 13-bit length. Control bit 2 keeps only n[6:0]. A resulting count of zero finishes without any write.
- R9: `done` pulses for one cycle when the count completes. `irq` pulses in the same cycle only when control bit 3 is set.
- R10: An `abort` pulse drops `armed` at the next edge and never produces `done`. Later triggers cause no writes until the channel is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Start pulse: fetch the record and arm |
| abort | input | 1 | Abort pulse: return to idle |
| desc_addr | input | 16 | Byte address of the record |
| sw_req | input | 1 | Software start pulse |
| trig_vec | input | NUM_TRIG-1 | Hardware trigger pulses, numbered 1 upward |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_word | output | 1 | Access is 16 bits wide |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data, low byte in [7:0] |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| armed | output | 1 | Channel is not idle |
| done | output | 1 | Completion pulse |
| irq | output | 1 | Completion interrupt pulse |
| prio | output | 2 | Priority field from control bits [1:0] |

## Verification
The properties assume three things about the inputs: `arm` and `abort` are single-cycle pulses, memory read data is valid exactly one cycle after a read request, and the memory never stalls. The bench's memory model answers every request with that fixed latency. It drives `arm`, `abort` and all triggers as one-cycle pulses on the falling edge. It fires a trigger only after the record fetch has had time to finish, and it never asserts `arm` while the channel is busy.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

   localparam int ADDR_W     = 16;
   localparam int LEN_W      = 13;
   localparam int DESC_BYTES = 8;

   typedef enum logic [2:0] {
      ST_IDLE, ST_DESC, ST_LOAD, ST_WAIT, ST_RD, ST_WR, ST_DONE
   } dma_state_e;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP1  = 2'd1,
      STEP_UP2  = 2'd2,
      STEP_DN1  = 2'd3
   } step_e;

   typedef struct packed {
      logic [ADDR_W-1:0] src;
      logic [ADDR_W-1:0] dst;
      logic [2:0]        vlen;
      logic [LEN_W-1:0]  len;
      logic              word;
      logic              repeat_en;
      logic              block_en;
      logic [4:0]        trig;
      step_e             src_step;
      step_e             dst_step;
      logic              irq_en;
      logic              len7;
      logic [1:0]        prio;
   } desc_t;

endpackage

// File: rtl/dma_desc_store.sv
module dma_desc_store
   import dma_chan_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [IDX_W-1:0] cap_idx,
   input  logic [7:0]       cap_byte,
   output desc_t            desc
);

   logic [7:0] rec_q [DESC_BYTES];

   for (genvar b = 0; b < DESC_BYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rec_q[b] <= 8'h00;
         end else if (cap_en && cap_idx == IDX_W'(b)) begin
            rec_q[b] <= cap_byte;
         end
      end
   end

   always_comb begin
      desc.src       = {rec_q[0], rec_q[1]};
      desc.dst       = {rec_q[2], rec_q[3]};
      desc.vlen      = rec_q[4][7:5];
      desc.len       = {rec_q[4][4:0], rec_q[5]};
      desc.word      = rec_q[6][7];
      desc.repeat_en = rec_q[6][6];
      desc.block_en  = rec_q[6][5];
      desc.trig      = rec_q[6][4:0];
      desc.src_step  = step_e'(rec_q[7][7:6]);
      desc.dst_step  = step_e'(rec_q[7][5:4]);
      desc.irq_en    = rec_q[7][3];
      desc.len7      = rec_q[7][2];
      desc.prio      = rec_q[7][1:0];
   end

endmodule

// File: rtl/dma_len_calc.sv
module dma_len_calc
   import dma_chan_pkg::*;
#(
   parameter int CNT_W = 13
) (
   input  logic [2:0]       vlen,
   input  logic [LEN_W-1:0] len,
   input  logic             len7,
   input  logic             word,
   input  logic [15:0]      first_item,
   output logic             is_var,
   output logic [CNT_W-1:0] var_cnt
);

   localparam int SUM_W = 17;

   logic [15:0]      n_val;
   logic [1:0]       offset;
   logic [SUM_W-1:0] sum;

   always_comb begin
      n_val = word ? first_item : {8'h00, first_item[7:0]};
      if (len7) n_val = n_val & 16'h007F;
      is_var = 1'b1;
      unique case (vlen)
         3'd1:    offset = 2'd1;
         3'd2:    offset = 2'd0;
         3'd3:    offset = 2'd2;
         3'd4:    offset = 2'd3;
         default: begin
            offset = 2'd0;
            is_var = 1'b0;
         end
      endcase
      sum = SUM_W'(n_val) + SUM_W'(offset);
      if (sum > SUM_W'(len)) var_cnt = CNT_W'(len);
      else                   var_cnt = CNT_W'(sum);
   end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
   import dma_chan_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   input  step_e             step,
   input  logic              word,
   output logic [ADDR_W-1:0] next_addr
);

   logic [ADDR_W-1:0] delta;

   always_comb begin
      unique case (step)
         STEP_HOLD: delta = '0;
         STEP_UP1:  delta = word ? ADDR_W'(2) : ADDR_W'(1);
         STEP_UP2:  delta = word ? ADDR_W'(4) : ADDR_W'(2);
         STEP_DN1:  delta = word ? {{(ADDR_W-2){1'b1}}, 2'b10} : '1;
         default:   delta = '0;
      endcase
      next_addr = addr + delta;
   end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
   import dma_chan_pkg::*;
#(
   parameter int NUM_TRIG = 31,
   parameter int CNT_W    = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                arm,
   input  logic                abort,
   input  logic [15:0]         desc_addr,
   input  logic                sw_req,
   input  logic [NUM_TRIG-1:1] trig_vec,
   output logic                mem_req,
   output logic                mem_we,
   output logic                mem_word,
   output logic [15:0]         mem_addr,
   output logic [15:0]         mem_wdata,
   input  logic [15:0]         mem_rdata,
   output logic                armed,
   output logic                done,
   output logic                irq,
   output logic [1:0]          prio
);

   localparam int IDX_W = $clog2(DESC_BYTES) + 1;

   if (NUM_TRIG < 2 || NUM_TRIG > 32) begin : g_bad_trig
      $error("NUM_TRIG must lie in 2..32");
   end
   if (CNT_W < LEN_W) begin : g_bad_cnt
      $error("CNT_W must hold the full descriptor length");
   end

   dma_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] dptr_q;
   logic [ADDR_W-1:0] src_q;
   logic [ADDR_W-1:0] dst_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              first_q;

   desc_t             desc;
   logic              cap_en;
   logic [IDX_W-1:0]  cap_idx;
   logic              is_var;
   logic [CNT_W-1:0]  var_cnt;
   logic [CNT_W-1:0]  cnt_use;
   logic              hw_hit;
   logic              trig_hit;

   logic [ADDR_W-1:0] cur_addr [2];
   logic [ADDR_W-1:0] nxt_addr [2];
   step_e             step_sel [2];

   assign cap_en  = (state_q == ST_DESC) && (idx_q != '0);
   assign cap_idx = idx_q - 1'b1;

   dma_desc_store #(.IDX_W(IDX_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_idx  (cap_idx),
      .cap_byte (mem_rdata[7:0]),
      .desc     (desc)
   );

   dma_len_calc #(.CNT_W(CNT_W)) u_len (
      .vlen       (desc.vlen),
      .len        (desc.len),
      .len7       (desc.len7),
      .word       (desc.word),
      .first_item (mem_rdata),
      .is_var     (is_var),
      .var_cnt    (var_cnt)
   );

   assign cur_addr[0] = src_q;
   assign cur_addr[1] = dst_q;
   assign step_sel[0] = desc.src_step;
   assign step_sel[1] = desc.dst_step;

   for (genvar s = 0; s < 2; s++) begin : g_side
      dma_addr_step u_step (
         .addr      (cur_addr[s]),
         .step      (step_sel[s]),
         .word      (desc.word),
         .next_addr (nxt_addr[s])
      );
   end

   always_comb begin
      hw_hit = 1'b0;
      for (int i = 1; i < NUM_TRIG; i++) begin
         if (desc.trig == 5'(i)) hw_hit = trig_vec[i];
      end
   end

   assign trig_hit = sw_req || hw_hit;
   assign cnt_use  = (first_q && is_var) ? var_cnt : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         dptr_q  <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         cnt_q   <= '0;
         first_q <= 1'b0;
      end else if (abort) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (arm) begin
                  state_q <= ST_DESC;
                  idx_q   <= '0;
                  dptr_q  <= desc_addr;
               end
            end
            ST_DESC: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == IDX_W'(DESC_BYTES)) state_q <= ST_LOAD;
            end
            ST_LOAD: begin
               src_q   <= desc.src;
               dst_q   <= desc.dst;
               cnt_q   <= CNT_W'(desc.len);
               first_q <= 1'b1;
               state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (trig_hit) begin
                  if (!is_var && cnt_q == '0) state_q <= ST_DONE;
                  else                        state_q <= ST_RD;
               end
            end
            ST_RD: begin
               state_q <= ST_WR;
            end
            ST_WR: begin
               if (cnt_use == '0) begin
                  state_q <= ST_DONE;
               end else begin
                  cnt_q   <= cnt_use - 1'b1;
                  first_q <= 1'b0;
                  src_q   <= nxt_addr[0];
                  dst_q   <= nxt_addr[1];
                  if (cnt_use == CNT_W'(1)) state_q <= ST_DONE;
                  else if (desc.block_en)   state_q <= ST_RD;
                  else                      state_q <= ST_WAIT;
               end
            end
            ST_DONE: begin
               state_q <= desc.repeat_en ? ST_LOAD : ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_word  = 1'b0;
      mem_addr  = '0;
      mem_wdata = desc.word ? mem_rdata : {8'h00, mem_rdata[7:0]};
      unique case (state_q)
         ST_DESC: begin
            mem_req  = (idx_q < IDX_W'(DESC_BYTES));
            mem_addr = dptr_q + ADDR_W'(idx_q);
         end
         ST_RD: begin
            mem_req  = 1'b1;
            mem_word = desc.word;
            mem_addr = src_q;
         end
         ST_WR: begin
            mem_req  = (cnt_use != '0);
            mem_we   = (cnt_use != '0);
            mem_word = desc.word;
            mem_addr = dst_q;
         end
         default: ;
      endcase
   end

   assign armed = (state_q != ST_IDLE);
   assign done  = (state_q == ST_DONE);
   assign irq   = (state_q == ST_DONE) && desc.irq_en;
   assign prio  = desc.prio;

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic arm,
   input logic abort,
   input logic armed,
   input logic done,
   input logic irq,
   input logic mem_req,
   input logic mem_we
);

   a_r1_arm_starts: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(arm));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !mem_req);

   a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(mem_req && !mem_we));

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done);

   a_r10_abort_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!armed && !done));

endmodule

bind dma_chan_engine dma_chan_engine_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .arm     (arm),
   .abort   (abort),
   .armed   (armed),
   .done    (done),
   .irq     (irq),
   .mem_req (mem_req),
   .mem_we  (mem_we)
);

// File: tb/tb_dma_chan_engine.sv
`timescale 1ns/1ps
module tb_dma_chan_engine;

   localparam int NT = 31;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm = 1'b0;
   logic          abort = 1'b0;
   logic [15:0]   desc_addr = '0;
   logic          sw_req = 1'b0;
   logic [NT-1:1] trig_vec = '0;
   logic          mem_req, mem_we, mem_word;
   logic [15:0]   mem_addr, mem_wdata;
   logic [15:0]   mem_rdata = '0;
   logic          armed, done, irq;
   logic [1:0]    prio;

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;
   int irq_cnt = 0;
   int wr_cnt = 0;

   logic [7:0] mem [4096];

   always #2 clk = ~clk;

   dma_chan_engine #(.NUM_TRIG(NT), .CNT_W(13)) dut (
      .clk, .rst_n, .arm, .abort, .desc_addr, .sw_req, .trig_vec,
      .mem_req, .mem_we, .mem_word, .mem_addr, .mem_wdata, .mem_rdata,
      .armed, .done, .irq, .prio
   );

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata[7:0];
            if (mem_word) mem[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata <= {mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (done) done_cnt <= done_cnt + 1;
         if (irq)  irq_cnt  <= irq_cnt + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic put_desc(input int base, input int src, input int dst,
                           input int vlen, input int len, input bit word,
                           input int mode, input int trig, input int sstep,
                           input int dstep, input bit irqen, input bit l7);
      mem[base]   = src[15:8];
      mem[base+1] = src[7:0];
      mem[base+2] = dst[15:8];
      mem[base+3] = dst[7:0];
      mem[base+4] = {vlen[2:0], len[12:8]};
      mem[base+5] = len[7:0];
      mem[base+6] = {word, mode[1:0], trig[4:0]};
      mem[base+7] = {sstep[1:0], dstep[1:0], irqen, l7, 2'b10};
   endtask

   task automatic do_arm(input int base);
      desc_addr = base[15:0];
      arm = 1'b1;
      cyc(1);
      arm = 1'b0;
      cyc(14);
   endtask

   task automatic pulse_sw();
      sw_req = 1'b1;
      cyc(1);
      sw_req = 1'b0;
   endtask

   task automatic pulse_hw(input int n);
      trig_vec[n] = 1'b1;
      cyc(1);
      trig_vec[n] = 1'b0;
   endtask

   task automatic wait_done(input int start, input string req);
      int k = 0;
      while (done_cnt == start && k < 300) begin
         cyc(1);
         k++;
      end
      chk(req, int'(done_cnt > start), 1);
   endtask

   task automatic t_reset();
      chk("R1 reset armed", armed, 0);
      chk("R9 reset done", done, 0);
      chk("R1 reset mem_req", mem_req, 0);
   endtask

   task automatic t_block_byte();
      int d0 = done_cnt;
      int i0 = irq_cnt;
      put_desc(12'h100, 12'h200, 12'h300, 0, 4, 0, 1, 0, 1, 1, 1, 0);
      for (int i = 0; i < 4; i++) mem[12'h200 + i] = 8'hA0 + 8'(i);
      do_arm(12'h100);
      chk("R1 armed after fetch", armed, 1);
      chk("R1 prio field", prio, 2);
      pulse_sw();
      wait_done(d0, "R3 block done");
      cyc(2);
      for (int i = 0; i < 4; i++) chk("R3 block data", mem[12'h300 + i], 8'hA0 + i);
      chk("R9 irq pulse", irq_cnt - i0, 1);
      chk("R9 single done", done_cnt - d0, 1);
      chk("R4 non-repeat idle", armed, 0);
   endtask

   task automatic t_single_trig();
      int d0 = done_cnt;
      int i0 = irq_cnt;
      put_desc(12'h110, 12'h210, 12'h310, 0, 3, 0, 0, 5, 0, 1, 0, 0);
      mem[12'h210] = 8'h5C;
      for (int i = 0; i < 3; i++) mem[12'h310 + i] = 8'h00;
      do_arm(12'h110);
      pulse_hw(4);
      cyc(10);
      chk("R2 other line ignored", mem[12'h310], 8'h00);
      pulse_hw(5);
      cyc(6);
      chk("R3 one item", mem[12'h310], 8'h5C);
      chk("R3 only one item", mem[12'h311], 8'h00);
      chk("R3 still armed", armed, 1);
      pulse_sw();
      cyc(6);
      chk("R2 sw_req also starts", mem[12'h311], 8'h5C);
      pulse_hw(5);
      wait_done(d0, "R3 single done");
      cyc(2);
      chk("R5 hold source", mem[12'h312], 8'h5C);
      chk("R9 no irq when disabled", irq_cnt - i0, 0);
      chk("R4 single disarms", armed, 0);
   endtask

   task automatic t_word_step();
      int d0 = done_cnt;
      put_desc(12'h120, 12'h400, 12'h50A, 0, 3, 1, 1, 0, 2, 3, 0, 0);
      for (int i = 0; i < 3; i++) begin
         mem[12'h400 + 4*i]     = 8'h11 * 8'(i + 1);
         mem[12'h400 + 4*i + 1] = 8'h11 * 8'(i + 1) + 8'h80;
      end
      mem[12'h50C] = 8'h00;
      do_arm(12'h120);
      pulse_sw();
      wait_done(d0, "R6 word done");
      cyc(2);
      for (int i = 0; i < 3; i++) begin
         chk("R6 word low byte", mem[12'h50A - 2*i], 8'h11 * (i + 1));
         chk("R5 word high byte", mem[12'h50A - 2*i + 1], ((8'h11 * (i + 1)) + 8'h80) & 8'hFF);
      end
      chk("R5 no stray write", mem[12'h50C], 8'h00);
   endtask

   task automatic t_var(input int vlen, input int len, input bit l7,
                        input int src, input int dst, input int first,
                        input int exp_n, input string req);
      int d0 = done_cnt;
      put_desc(12'h130, src, dst, vlen, len, 0, 1, 0, 1, 1, 0, l7);
      mem[src] = first[7:0];
      for (int i = 1; i < 12; i++) mem[src + i] = 8'hC0 + 8'(i);
      for (int i = 0; i < 12; i++) mem[dst + i] = 8'hEE;
      do_arm(12'h130);
      pulse_sw();
      wait_done(d0, req);
      cyc(2);
      for (int i = 0; i < exp_n; i++) chk(req, mem[dst + i], (i == 0) ? first : (8'hC0 + i));
      chk(req, mem[dst + exp_n], 8'hEE);
   endtask

   task automatic t_zero_fixed();
      int d0 = done_cnt;
      int w0;
      put_desc(12'h140, 12'h680, 12'h780, 0, 0, 0, 0, 0, 1, 1, 0, 0);
      do_arm(12'h140);
      w0 = wr_cnt;
      pulse_sw();
      wait_done(d0, "R7 zero length done");
      chk("R7 zero length no write", wr_cnt - w0, 0);
   endtask

   task automatic t_repeat();
      int d0 = done_cnt;
      int i0 = irq_cnt;
      put_desc(12'h150, 12'h800, 12'h900, 0, 2, 0, 3, 0, 1, 1, 1, 0);
      mem[12'h800] = 8'h11;
      mem[12'h801] = 8'h22;
      do_arm(12'h150);
      pulse_sw();
      wait_done(d0, "R4 first pass");
      cyc(4);
      chk("R4 stays armed", armed, 1);
      chk("R4 first pass data", mem[12'h901], 8'h22);
      chk("R9 irq in repeat", irq_cnt - i0, 1);
      mem[12'h800] = 8'h33;
      mem[12'h801] = 8'h44;
      pulse_sw();
      wait_done(d0 + 1, "R4 second pass");
      cyc(4);
      chk("R4 reloaded dst", mem[12'h900], 8'h33);
      chk("R4 reloaded src", mem[12'h901], 8'h44);
      abort = 1'b1;
      cyc(1);
      abort = 1'b0;
      cyc(1);
   endtask

   task automatic t_abort();
      int d0;
      put_desc(12'h160, 12'hA00, 12'hB00, 0, 3, 0, 0, 0, 1, 1, 0, 0);
      for (int i = 0; i < 3; i++) begin
         mem[12'hA00 + i] = 8'hE1 + 8'(i);
         mem[12'hB00 + i] = 8'h00;
      end
      do_arm(12'h160);
      d0 = done_cnt;
      pulse_sw();
      cyc(6);
      abort = 1'b1;
      cyc(1);
      abort = 1'b0;
      chk("R10 abort disarms", armed, 0);
      pulse_sw();
      cyc(10);
      chk("R10 first item kept", mem[12'hB00], 8'hE1);
      chk("R10 no write after abort", mem[12'hB01], 8'h00);
      chk("R10 no done on abort", done_cnt - d0, 0);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      cyc(3);
      t_reset();
      rst_n = 1'b1;
      cyc(2);
      t_block_byte();
      t_single_trig();
      t_word_step();
      t_var(1, 10, 0, 12'h600, 12'h700, 8'h02, 3, "R8 plus one");
      t_var(4, 5, 0, 12'h610, 12'h710, 8'h0A, 5, "R8 capped at length");
      t_var(2, 10, 0, 12'h620, 12'h720, 8'h00, 0, "R8 zero count");
      t_var(2, 10, 1, 12'h630, 12'h730, 8'h83, 3, "R8 seven-bit length");
      t_var(5, 2, 0, 12'h640, 12'h740, 8'h09, 2, "R7 reserved mode fixed");
      t_zero_fixed();
      t_repeat();
      t_abort();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule